// File: doc/BRIEF.md
# Multiphase Interleaved Phase Sequencer

This block sets the firing order of an interleaved multiphase PWM controller with up to six phases. While reset is held, it reads four strap-sense levels. Each level shows whether the output pin of phase 3, 4, 5 or 6 is tied high. From the lowest strapped pin it fixes the number of active phases, between two and six. After reset is released the straps are ignored and the phase count stays frozen.

Each switching sub-period tick moves the rotation on by one step. On the cycle after the tick, the selected phase gets a single-cycle one-hot trigger. The rotation is sequential for two, three, five and six phases. With four phases it runs 1, 3, 4, 2. A separate load-transient request drives a mask of all active phases, so that every active phase turns on at once. The active phase count is also an output, for the current-averaging logic downstream.

Top module: `phase_rotor`

## Requirements
- R1: While `rstN` is low, `phaseSel` and `allOnVec` are zero. When reset is released, the rotation restarts at phase 1.
- R2: If no strap is high, `phaseCount` is 6 and the ticks select phases 1,2,3,4,5,6 in that order, then wrap back to 1.
- R3: `strapHi[k]` (k=0 is the phase-3 pin, k=3 the phase-6 pin) gives `phaseCount` = k+2. When several straps are high, the lowest k sets the count.
- R4: Straps are sampled only while `rstN` is low. Changing them after release leaves `phaseCount` and the rotation unchanged.
- R5: With four active phases, the ticks select phases 1,3,4,2, then wrap back to 1.
- R6: With two, three or five active phases, the ticks select phases 1 up to the count in ascending order, then wrap back to 1.
- R7: A tick sampled at a clock edge makes exactly one bit of `phaseSel` high for the one following cycle. `phaseSel` bit i stands for phase i+1. Without a tick, `phaseSel` is zero.
- R8: No `phaseSel` bit at or above `phaseCount` ever goes high.
- R9: `boostReq` sampled high at an edge sets `allOnVec` to ones in bits 0 to `phaseCount`-1, and zeros above, for the following cycle. Otherwise `allOnVec` is zero. A boost request does not change the rotation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset; straps are sampled while it is low |
| tick | input | 1 | One-cycle strobe for each switching sub-period |
| strapHi | input | 4 | Strap sense for the pins of phases 3..6 (bit 0 = phase 3) |
| boostReq | input | 1 | Request to turn all active phases on together |
| phaseSel | output | 6 | One-hot phase trigger; bit i = phase i+1 |
| phaseCount | output | 3 | Number of active phases, 2 to 6 |
| allOnVec | output | 6 | Mask of all active phases while a boost is requested |

## Verification
The assertions assume that the straps settle before reset is released, and that `tick` and `boostReq` are synchronous strobes that are only sampled once reset is high. Under those assumptions, triggers stay one-hot and inside the active set, and the count stays stable. The stimulus drives every input on the falling edge. It sets the straps only while reset is asserted, except in the one scenario that tests that later strap changes are ignored. It also keeps ticks to single cycles separated by idle cycles, so each trigger pulse can be seen on its own.

// File: rtl/phase_rotor_pkg.sv
package phase_rotor_pkg;
  localparam int MAX_PHASES = 6;
  localparam int CNT_W = $clog2(MAX_PHASES + 1);

  typedef struct packed {
    logic fire;
    logic wrap;
  } rotStrobe_t;
endpackage

// File: rtl/phase_rotor_ctrl.sv
module phase_rotor_ctrl
  import phase_rotor_pkg::*;
#(
  parameter int PHASES = MAX_PHASES,
  parameter int CW = CNT_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 tick,
  input  logic [PHASES-3:0]    strapHi,
  output logic [CW-1:0]        phaseCount,
  output logic [CW-1:0]        stepIdx,
  output rotStrobe_t           strobe
);
  localparam int STRAP_W = PHASES - 2;

  logic [CW-1:0] strapCount;

  // lowest strapped pin wins: scan downward so the last hit is the lowest
  always_comb begin
    strapCount = CW'(PHASES);
    for (int k = STRAP_W - 1; k >= 0; k--) begin
      if (strapHi[k]) strapCount = CW'(k + 2);
    end
  end

  always_comb begin
    strobe.fire = tick;
    strobe.wrap = (stepIdx == phaseCount - CW'(1));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phaseCount <= strapCount;
      stepIdx    <= '0;
    end else if (strobe.fire) begin
      stepIdx <= strobe.wrap ? '0 : stepIdx + CW'(1);
    end
  end
endmodule

// File: rtl/phase_rotor_dp.sv
module phase_rotor_dp
  import phase_rotor_pkg::*;
#(
  parameter int PHASES = MAX_PHASES,
  parameter int CW = CNT_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  rotStrobe_t        strobe,
  input  logic [CW-1:0]     stepIdx,
  input  logic [CW-1:0]     phaseCount,
  input  logic              boostReq,
  output logic [PHASES-1:0] phaseSel,
  output logic [PHASES-1:0] allOnVec
);
  logic [PHASES-1:0] activeMask;
  logic [PHASES-1:0] hitVec;
  logic [CW-1:0]     slot;

  // four-phase rotation interleaves as 1,3,4,2; others are sequential
  always_comb begin
    slot = stepIdx;
    if (phaseCount == CW'(4)) begin
      case (stepIdx)
        CW'(0):  slot = CW'(0);
        CW'(1):  slot = CW'(2);
        CW'(2):  slot = CW'(3);
        default: slot = CW'(1);
      endcase
    end
  end

  for (genvar i = 0; i < PHASES; i++) begin : g_lane
    assign activeMask[i] = (CW'(i) < phaseCount);
    assign hitVec[i]     = (slot == CW'(i)) && activeMask[i];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phaseSel <= '0;
      allOnVec <= '0;
    end else begin
      phaseSel <= strobe.fire ? hitVec : '0;
      allOnVec <= boostReq ? activeMask : '0;
    end
  end
endmodule

// File: rtl/phase_rotor.sv
module phase_rotor
  import phase_rotor_pkg::*;
#(
  parameter int PHASES = MAX_PHASES,
  parameter int CW = CNT_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic [PHASES-3:0] strapHi,
  input  logic              boostReq,
  output logic [PHASES-1:0] phaseSel,
  output logic [CW-1:0]     phaseCount,
  output logic [PHASES-1:0] allOnVec
);
  rotStrobe_t    strobe;
  logic [CW-1:0] stepIdx;

  phase_rotor_ctrl #(.PHASES(PHASES), .CW(CW)) ctrl_i (
    .clk(clk), .rstN(rstN), .tick(tick), .strapHi(strapHi),
    .phaseCount(phaseCount), .stepIdx(stepIdx), .strobe(strobe)
  );

  phase_rotor_dp #(.PHASES(PHASES), .CW(CW)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .stepIdx(stepIdx),
    .phaseCount(phaseCount), .boostReq(boostReq),
    .phaseSel(phaseSel), .allOnVec(allOnVec)
  );
endmodule

// File: rtl/phase_rotor_checker.sv
module phase_rotor_checker #(
  parameter int PHASES = 6,
  parameter int CW = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              tick,
  input logic              boostReq,
  input logic [PHASES-1:0] phaseSel,
  input logic [CW-1:0]     phaseCount,
  input logic [PHASES-1:0] allOnVec
);
  logic [PHASES-1:0] expMask;
  always_comb begin
    for (int i = 0; i < PHASES; i++) expMask[i] = (i < int'(phaseCount));
  end

  assert_onehot_after_tick_R7: assert property (@(posedge clk) disable iff (!rstN)
    tick |=> $onehot(phaseSel));
  assert_idle_no_tick_R7: assert property (@(posedge clk) disable iff (!rstN)
    !tick |=> (phaseSel == '0));
  assert_inactive_silent_R8: assert property (@(posedge clk) disable iff (!rstN)
    (phaseSel & ~expMask) == '0);
  assert_count_frozen_R4: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> $stable(phaseCount));
  assert_boost_mask_R9: assert property (@(posedge clk) disable iff (!rstN)
    boostReq |=> (allOnVec == expMask));
  assert_count_range_R3: assert property (@(posedge clk) disable iff (!rstN)
    (phaseCount >= CW'(2)) && (phaseCount <= CW'(PHASES)));
endmodule

bind phase_rotor phase_rotor_checker #(.PHASES(PHASES), .CW(CW)) chk_i (
  .clk(clk), .rstN(rstN), .tick(tick), .boostReq(boostReq),
  .phaseSel(phaseSel), .phaseCount(phaseCount), .allOnVec(allOnVec)
);

// File: tb/phase_rotor_tb_top.sv
module phase_rotor_tb_top;
  logic       clk = 0;
  logic       rstN = 0;
  logic       tick = 0;
  logic [3:0] strapHi = '0;
  logic       boostReq = 0;
  logic [5:0] phaseSel;
  logic [2:0] phaseCount;
  logic [5:0] allOnVec;
  int nChecks = 0;
  int nFails = 0;

  always #2 clk = ~clk;

  phase_rotor dut_i (
    .clk(clk), .rstN(rstN), .tick(tick), .strapHi(strapHi),
    .boostReq(boostReq), .phaseSel(phaseSel),
    .phaseCount(phaseCount), .allOnVec(allOnVec)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic doReset(input logic [3:0] straps);
    @(negedge clk);
    rstN = 0; strapHi = straps; tick = 0; boostReq = 0;
    repeat (3) @(negedge clk);
    check("R1", {2'b0, phaseSel}, 8'h00);
    check("R1", {2'b0, allOnVec}, 8'h00);
    rstN = 1;
    @(negedge clk);
  endtask

  // one tick, then check pulse on next cycle and silence after
  task automatic pulse(input string req, input int phaseNum);
    tick = 1;
    @(negedge clk);
    tick = 0;
    check(req, {2'b0, phaseSel}, 8'(1 << (phaseNum - 1)));
    @(negedge clk);
    check("R7", {2'b0, phaseSel}, 8'h00);
  endtask

  task automatic runSeq(input string req, input logic [3:0] straps,
                        input int expCount, input int seq[]);
    doReset(straps);
    check("R3", {5'b0, phaseCount}, 8'(expCount));
    foreach (seq[i]) pulse(req, seq[i]);
    pulse(req, 1);  // wrap
  endtask

  task automatic testStrapIgnored;
    doReset(4'b0000);
    pulse("R4", 1);
    strapHi = 4'b0001;
    @(negedge clk);
    check("R4", {5'b0, phaseCount}, 8'd6);
    pulse("R4", 2);
    pulse("R4", 3);
    pulse("R8", 4);
  endtask

  task automatic testBoost;
    doReset(4'b0100);
    pulse("R5", 1);
    boostReq = 1; tick = 1;
    @(negedge clk);
    boostReq = 0; tick = 0;
    check("R9", {2'b0, allOnVec}, 8'h0F);
    check("R5", {2'b0, phaseSel}, 8'h04);
    @(negedge clk);
    check("R9", {2'b0, allOnVec}, 8'h00);
    pulse("R9", 4);
    pulse("R9", 2);
  endtask

  task automatic testMidReset;
    doReset(4'b0010);
    pulse("R6", 1);
    pulse("R6", 2);
    doReset(4'b0010);
    pulse("R1", 1);
  endtask

  initial begin
    runSeq("R2", 4'b0000, 6, '{1, 2, 3, 4, 5, 6});
    runSeq("R5", 4'b0100, 4, '{1, 3, 4, 2});
    runSeq("R6", 4'b0001, 2, '{1, 2});
    runSeq("R6", 4'b0010, 3, '{1, 2, 3});
    runSeq("R6", 4'b1000, 5, '{1, 2, 3, 4, 5});
    runSeq("R3", 4'b0110, 3, '{1, 2, 3});
    runSeq("R3", 4'b1111, 2, '{1, 2});
    testStrapIgnored();
    testBoost();
    testMidReset();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule